// File: doc/BRIEF.md
# Fast Ethernet PHY Management Register File

This block models the management registers of a Fast Ethernet PHY as they appear over a simple parallel access port. A host presents a PHY address and a register index with either a write strobe and 16-bit data or a read strobe, and receives 16-bit read data one clock later. The block holds the control, status, advertisement and link-partner ability words and returns fixed identifier words. It also performs the soft reset requested through the control word, and it follows a link-up input.

Only one PHY address, set by a parameter with default 1, gets an answer. Any other address reads as all ones, and writes to it have no effect. A change on the link input updates the link bit of the status word and replaces the whole link-partner word. The serial management waveform, real autonegotiation timing and media-side behaviour are not part of this block.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, and with the link down, the registers read as follows: index 0 (control) reads 0x3100, index 1 (status) reads 0x7848, index 4 (advertisement) reads 0x01E1 and index 5 (link partner) reads 0x0080. The read data output is 0x0000 before the first read.
- R2: A read at any PHY address other than 1 returns 0xFFFF. A write at such an address changes no register.
- R3: At address 1, index 2 reads 0x0000 and index 3 reads 0x8201. Every index from 6 to 31 reads 0x0000.
- R4: A control write (index 0) with bit 15 clear stores the written value unchanged.
- R5: A control write with bit 15 set does not store the value. It loads control 0x3100 and advertisement 0x01E1, and status and link-partner stay consistent with the current link state.
- R6: The link input takes effect at the next clock edge. With the link up, status bit 2 is set (status 0x784C) and the link-partner word is 0x01E1. With the link down, status bit 2 is clear and the link-partner word is 0x0080.
- R7: Writes to index 1 (status), 2, 3 and 5 (link partner) are ignored.
- R8: A write to index 4 (advertisement) stores the written value.
- R9: Read data appears on the clock edge that samples the read strobe and holds until the next read. A read in the same cycle as a write, or as a link change, returns the value held before that update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Link state from the media side, 1 = up |
| phy_addr | input | 5 | PHY address of the access |
| reg_idx | input | 5 | Register index of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |

## Verification
Register state changes on the edge that samples a write strobe or a link change. Read data is loaded on the edge that samples the read strobe, so a result is due one edge after its stimulus. The bench drives every input on the falling edge and samples read data on the following falling edge. That edge is the first point at which the new value can appear. For the same-cycle cases, read strobe and update are driven together, the old value is expected at that sample, and a second read must then show the new value.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
   localparam int unsigned NUM_REGS   = 6;
   localparam int unsigned IDX_CTRL   = 0;
   localparam int unsigned IDX_STAT   = 1;
   localparam int unsigned IDX_ID1    = 2;
   localparam int unsigned IDX_ID2    = 3;
   localparam int unsigned IDX_ADV    = 4;
   localparam int unsigned IDX_LPA    = 5;

   localparam int unsigned CTRL_RESET_BIT = 15;
   localparam int unsigned STAT_LINK_BIT  = 2;

   // control: full duplex, autoneg enable, 100 Mb/s
   localparam logic [15:0] CTRL_DEFAULT = 16'h3100;
   // status capability bits, link bit excluded
   localparam logic [15:0] STAT_CAPS    = 16'h7848;
   localparam logic [15:0] ADV_DEFAULT  = 16'h01E1;
   localparam logic [15:0] LPA_LINK_UP  = 16'h01E1;
   localparam logic [15:0] LPA_LINK_DN  = 16'h0080;
   localparam logic [15:0] FOREIGN_WORD = 16'hFFFF;
endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
   import phy_mgmt_pkg::*;
#(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned PHY_ADDR = 1
) (
   input  logic [ADDR_W-1:0]   phy_addr,
   input  logic [IDX_W-1:0]    reg_idx,
   output logic                addr_hit,
   output logic [NUM_REGS-1:0] reg_sel
);
   if (NUM_REGS > (1 << IDX_W)) begin : g_idx_chk
      $error("IDX_W too narrow for the register set");
   end
   if (PHY_ADDR >= (1 << ADDR_W)) begin : g_addr_chk
      $error("PHY_ADDR does not fit in ADDR_W");
   end

   assign addr_hit = (phy_addr == ADDR_W'(PHY_ADDR));

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
      assign reg_sel[g] = addr_hit && (reg_idx == IDX_W'(g));
   end
endmodule

// File: rtl/phy_mgmt_store.sv
module phy_mgmt_store
   import phy_mgmt_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                link_up,
   input  logic                wr_en,
   input  logic [NUM_REGS-1:0] reg_sel,
   input  logic [DATA_W-1:0]   wr_data,
   output logic [DATA_W-1:0]   ctrl_o,
   output logic [DATA_W-1:0]   stat_o,
   output logic [DATA_W-1:0]   adv_o,
   output logic [DATA_W-1:0]   lpa_o
);
   logic              link_q;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] adv_q;
   logic              wr_ctrl;
   logic              wr_adv;
   logic              soft_rst;

   assign wr_ctrl  = wr_en && reg_sel[IDX_CTRL];
   assign wr_adv   = wr_en && reg_sel[IDX_ADV];
   assign soft_rst = wr_ctrl && wr_data[CTRL_RESET_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q <= 1'b0;
         ctrl_q <= CTRL_DEFAULT;
         adv_q  <= ADV_DEFAULT;
      end else begin
         link_q <= link_up;
         if (soft_rst) begin
            ctrl_q <= CTRL_DEFAULT;
            adv_q  <= ADV_DEFAULT;
         end else if (wr_ctrl) begin
            ctrl_q <= wr_data;
         end else if (wr_adv) begin
            adv_q  <= wr_data;
         end
      end
   end

   // status and link-partner words are derived from the sampled link state,
   // so a soft reset re-applies the link automatically
   always_comb begin
      stat_o = STAT_CAPS;
      stat_o[STAT_LINK_BIT] = link_q;
      lpa_o  = link_q ? LPA_LINK_UP : LPA_LINK_DN;
   end

   assign ctrl_o = ctrl_q;
   assign adv_o  = adv_q;

   AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wr_data[CTRL_RESET_BIT]) |=> (ctrl_o == $past(wr_data))); // R4
   AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ctrl_o == CTRL_DEFAULT && adv_o == ADV_DEFAULT)); // R5
   AST_LINK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (stat_o[STAT_LINK_BIT] == $past(link_up))); // R6
   AST_LINK_DOWN_LPA: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up |=> (lpa_o == LPA_LINK_DN)); // R6
   AST_ADV_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_adv |=> (adv_o == $past(wr_data))); // R8
endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
   import phy_mgmt_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter logic [15:0] ID1_VALUE  = 16'h0000,
   parameter logic [15:0] ID2_VALUE  = 16'h8201,
   parameter bit          HOLD_RDATA = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_en,
   input  logic                addr_hit,
   input  logic [NUM_REGS-1:0] reg_sel,
   input  logic [DATA_W-1:0]   ctrl_i,
   input  logic [DATA_W-1:0]   stat_i,
   input  logic [DATA_W-1:0]   adv_i,
   input  logic [DATA_W-1:0]   lpa_i,
   output logic [DATA_W-1:0]   rd_data
);
   logic [DATA_W-1:0] rd_next;
   logic [DATA_W-1:0] rd_q;

   always_comb begin
      rd_next = '0;
      if (!addr_hit)                rd_next = FOREIGN_WORD;
      else if (reg_sel[IDX_CTRL])   rd_next = ctrl_i;
      else if (reg_sel[IDX_STAT])   rd_next = stat_i;
      else if (reg_sel[IDX_ID1])    rd_next = ID1_VALUE;
      else if (reg_sel[IDX_ID2])    rd_next = ID2_VALUE;
      else if (reg_sel[IDX_ADV])    rd_next = adv_i;
      else if (reg_sel[IDX_LPA])    rd_next = lpa_i;
   end

   if (HOLD_RDATA) begin : g_hold
      always_ff @(posedge clk) begin
         if (!rst_n)     rd_q <= '0;
         else if (rd_en) rd_q <= rd_next;
      end
      AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> $stable(rd_data)); // R9
   end else begin : g_clear
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= rd_en ? rd_next : '0;
      end
   end

   assign rd_data = rd_q;

   AST_FOREIGN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !addr_hit) |=> (rd_data == FOREIGN_WORD)); // R2
   AST_ID2_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_sel[IDX_ID2]) |=> (rd_data == ID2_VALUE)); // R3
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
   import phy_mgmt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned IDX_W      = 5,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned PHY_ADDR   = 1,
   parameter logic [15:0] ID1_VALUE  = 16'h0000,
   parameter logic [15:0] ID2_VALUE  = 16'h8201,
   parameter bit          HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic [ADDR_W-1:0] phy_addr,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W != 16) begin : g_width_chk
      $error("management words are 16 bits wide");
   end

   logic                addr_hit;
   logic [NUM_REGS-1:0] reg_sel;
   logic [DATA_W-1:0]   ctrl_w;
   logic [DATA_W-1:0]   stat_w;
   logic [DATA_W-1:0]   adv_w;
   logic [DATA_W-1:0]   lpa_w;

   phy_mgmt_decode #(
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W),
      .PHY_ADDR (PHY_ADDR)
   ) u_decode (
      .phy_addr (phy_addr),
      .reg_idx  (reg_idx),
      .addr_hit (addr_hit),
      .reg_sel  (reg_sel)
   );

   phy_mgmt_store #(
      .DATA_W (DATA_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_up (link_up),
      .wr_en   (wr_en),
      .reg_sel (reg_sel),
      .wr_data (wr_data),
      .ctrl_o  (ctrl_w),
      .stat_o  (stat_w),
      .adv_o   (adv_w),
      .lpa_o   (lpa_w)
   );

   phy_mgmt_rdmux #(
      .DATA_W     (DATA_W),
      .ID1_VALUE  (ID1_VALUE),
      .ID2_VALUE  (ID2_VALUE),
      .HOLD_RDATA (HOLD_RDATA)
   ) u_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .addr_hit (addr_hit),
      .reg_sel  (reg_sel),
      .ctrl_i   (ctrl_w),
      .stat_i   (stat_w),
      .adv_i    (adv_w),
      .lpa_i    (lpa_w),
      .rd_data  (rd_data)
   );
endmodule

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        link_up = 1'b0;
   logic [4:0]  phy_addr = '0;
   logic [4:0]  reg_idx = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [15:0] rd_data;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phy_mgmt_regs u_phy_mgmt_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_up (link_up),
      .phy_addr(phy_addr),
      .reg_idx (reg_idx),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data)
   );

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic mgmt_write(input logic [4:0] a, input logic [4:0] i,
                             input logic [15:0] d);
      @(negedge clk);
      phy_addr = a; reg_idx = i; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic mgmt_read(input logic [4:0] a, input logic [4:0] i,
                            output logic [15:0] v);
      @(negedge clk);
      phy_addr = a; reg_idx = i; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic expect_reg(input string req, input logic [4:0] i,
                             input logic [15:0] exp);
      logic [15:0] v;
      mgmt_read(5'd1, i, v);
      check(req, $sformatf("idx %0d", i), v, exp);
   endtask

   task automatic test_reset_values();
      check("R1", "rdata after reset", rd_data, 16'h0000);
      expect_reg("R1", 5'd0, 16'h3100);
      expect_reg("R1", 5'd1, 16'h7848);
      expect_reg("R1", 5'd4, 16'h01E1);
      expect_reg("R1", 5'd5, 16'h0080);
   endtask

   task automatic test_foreign_addr();
      logic [15:0] v;
      mgmt_read(5'd0, 5'd0, v);
      check("R2", "addr 0 read", v, 16'hFFFF);
      mgmt_read(5'd31, 5'd2, v);
      check("R2", "addr 31 read", v, 16'hFFFF);
      mgmt_write(5'd2, 5'd4, 16'h0000);
      mgmt_write(5'd3, 5'd0, 16'h0001);
      expect_reg("R2", 5'd4, 16'h01E1);
      expect_reg("R2", 5'd0, 16'h3100);
   endtask

   task automatic test_ids_unknown();
      expect_reg("R3", 5'd2, 16'h0000);
      expect_reg("R3", 5'd3, 16'h8201);
      expect_reg("R3", 5'd6, 16'h0000);
      expect_reg("R3", 5'd31, 16'h0000);
   endtask

   task automatic test_ctrl_store();
      mgmt_write(5'd1, 5'd0, 16'h1234);
      expect_reg("R4", 5'd0, 16'h1234);
      mgmt_write(5'd1, 5'd0, 16'h7FFF);
      expect_reg("R4", 5'd0, 16'h7FFF);
   endtask

   task automatic test_adv_store();
      mgmt_write(5'd1, 5'd4, 16'h0A5A);
      expect_reg("R8", 5'd4, 16'h0A5A);
   endtask

   task automatic test_link_up();
      // link change and read in the same cycle: old status expected
      @(negedge clk);
      link_up = 1'b1; phy_addr = 5'd1; reg_idx = 5'd1; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check("R9", "status read at link edge", rd_data, 16'h7848);
      expect_reg("R6", 5'd1, 16'h784C);
      expect_reg("R6", 5'd5, 16'h01E1);
   endtask

   task automatic test_read_only();
      mgmt_write(5'd1, 5'd1, 16'h0000);
      mgmt_write(5'd1, 5'd2, 16'hFFFF);
      mgmt_write(5'd1, 5'd3, 16'h0000);
      mgmt_write(5'd1, 5'd5, 16'h0000);
      expect_reg("R7", 5'd1, 16'h784C);
      expect_reg("R7", 5'd2, 16'h0000);
      expect_reg("R7", 5'd3, 16'h8201);
      expect_reg("R7", 5'd5, 16'h01E1);
   endtask

   task automatic test_soft_reset();
      mgmt_write(5'd1, 5'd0, 16'h8000);
      expect_reg("R5", 5'd0, 16'h3100);
      expect_reg("R5", 5'd4, 16'h01E1);
      expect_reg("R5", 5'd1, 16'h784C);
      expect_reg("R5", 5'd5, 16'h01E1);
   endtask

   task automatic test_link_down();
      @(negedge clk);
      link_up = 1'b0;
      expect_reg("R6", 5'd1, 16'h7848);
      expect_reg("R6", 5'd5, 16'h0080);
   endtask

   task automatic test_same_cycle_rw();
      @(negedge clk);
      phy_addr = 5'd1; reg_idx = 5'd0; wr_data = 16'h0055;
      wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R9", "read during write", rd_data, 16'h3100);
      expect_reg("R9", 5'd0, 16'h0055);
      repeat (3) @(negedge clk);
      check("R9", "rdata held while idle", rd_data, 16'h0055);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset_values();
      test_foreign_addr();
      test_ids_unknown();
      test_ctrl_store();
      test_adv_store();
      test_link_up();
      test_read_only();
      test_soft_reset();
      test_link_down();
      test_same_cycle_rw();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule